// File: doc/BRIEF.md
# Compare-and-branch resolution unit

This unit settles conditional branches for a small 32-bit processor that uses 16-bit instruction words. Branching happens in two steps. A compare instruction copies its two register operands into a pair of holding registers and computes no flags at that point. A later branch instruction names a relation, tests it against the held pair, and produces either the sequential address or a PC-relative target.

Signed and unsigned orderings are evaluated only when the branch resolves. Because of that, one compare can serve any of the ten relations. A branch whose condition code is not defined returns the faulting PC and raises a bad-condition flag, so that the exception logic outside this unit can take over.

The results are registered. The next PC, the taken flag and the bad-condition flag appear on the clock edge that samples the branch strobe. They keep their values until the next recognised branch.

Top module: `cbr_resolve_unit`

## Requirements
- R1: After synchronous reset, `next_pc`, `br_taken` and `bad_cond` are all 0, and both holding registers read as 0. An equal-relation branch issued before any compare is therefore taken.
- R2: The holding registers load `cmp_lhs` and `cmp_rhs` only on a clock edge where `cmp_valid` is 1. Operand changes while `cmp_valid` is 0 have no effect on later branch outcomes.
- R3: When `cmp_valid` and `br_valid` are both 1 in the same cycle, the branch is judged against the pair held before that cycle. The new pair applies from the next branch onward.
- R4: Condition code 0 (bits 13:10 of `br_word`) is taken when the held operands are equal. Code 1 is taken when they differ.
- R5: The signed relations are taken when first-operand vs second-operand, both read as two's complement, satisfies: code 2 less-than, code 3 greater-than, code 6 greater-or-equal, code 7 less-or-equal.
- R6: The unsigned relations are taken when the same comparison, both operands read as unsigned, satisfies: code 4 less-than, code 5 greater-than, code 8 greater-or-equal, code 9 less-or-equal.
- R7: A taken branch sets `next_pc` to `cur_pc + 2 + offset`. The offset is bits 9:0 of `br_word`, sign-extended and multiplied by two, covering -1024 to +1022.
- R8: A branch that is not taken sets `next_pc` to `cur_pc + 2`.
- R9: Condition codes 10 to 15 set `bad_cond` to 1, `br_taken` to 0 and `next_pc` to the unchanged `cur_pc`. A legal branch clears `bad_cond`.
- R10: The outputs change only on the clock edge that samples `br_valid` = 1 with a branch word. In all other cycles they hold, including cycles with compares.
- R11: A word with `br_valid` = 1 is recognised as a branch only if bits 15 and 14 are both 1. Any other word is ignored and leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | 32 | Byte address of the branch word being resolved |
| br_word | input | 16 | Branch instruction word |
| br_valid | input | 1 | Branch strobe, one cycle per branch |
| cmp_valid | input | 1 | Compare strobe, loads the holding registers |
| cmp_lhs | input | 32 | First compare operand |
| cmp_rhs | input | 32 | Second compare operand |
| next_pc | output | 32 | Resolved next fetch address |
| br_taken | output | 1 | Last branch was taken |
| bad_cond | output | 1 | Last branch used an undefined condition code |

## Verification
The two functions that can meet in one cycle are the operand latch and the branch resolution. A compare and a branch are both driven in the same cycle, with a new pair that would flip the outcome of an equal test. The branch result is judged against the old pair, then a second branch without a compare must show the outcome for the new pair. The same idea is applied to idle operand changes and to non-branch words: each is sent between two known branches, and the outputs are checked before the next branch is sent.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    localparam int unsigned CBR_XLEN      = 32;
    localparam int unsigned CBR_IW        = 16;
    localparam int unsigned CBR_COND_LSB  = 10;
    localparam int unsigned CBR_COND_W    = 4;
    localparam int unsigned CBR_OFF_W     = 10;
    localparam int unsigned CBR_STEP      = 2;
    localparam int unsigned CBR_NUM_RELS  = 10;

    typedef enum logic [CBR_COND_W-1:0] {
        REL_EQ  = 4'd0,
        REL_NE  = 4'd1,
        REL_SLT = 4'd2,
        REL_SGT = 4'd3,
        REL_ULT = 4'd4,
        REL_UGT = 4'd5,
        REL_SGE = 4'd6,
        REL_SLE = 4'd7,
        REL_UGE = 4'd8,
        REL_ULE = 4'd9
    } rel_e;

    typedef struct packed {
        logic                 is_branch;
        logic                 cond_ok;
        rel_e                 rel;
        logic [CBR_OFF_W-1:0] off_raw;
    } br_fields_t;

    typedef struct packed {
        logic eq;
        logic slt;
        logic ult;
    } cmp_summary_t;

    function automatic logic rel_pick(input rel_e rel, input cmp_summary_t s);
        logic sgt;
        logic ugt;
        sgt = !s.slt && !s.eq;
        ugt = !s.ult && !s.eq;
        case (rel)
            REL_EQ:  return s.eq;
            REL_NE:  return !s.eq;
            REL_SLT: return s.slt;
            REL_SGT: return sgt;
            REL_ULT: return s.ult;
            REL_UGT: return ugt;
            REL_SGE: return !s.slt;
            REL_SLE: return !sgt;
            REL_UGE: return !s.ult;
            REL_ULE: return !ugt;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cbr_hold_regs.sv
module cbr_hold_regs
    import cbr_pkg::*;
#(
    parameter int unsigned XLEN = CBR_XLEN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmp_valid,
    input  logic [XLEN-1:0] cmp_lhs,
    input  logic [XLEN-1:0] cmp_rhs,
    output logic [XLEN-1:0] hold_a,
    output logic [XLEN-1:0] hold_b
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_a <= '0;
            hold_b <= '0;
        end else if (cmp_valid) begin
            hold_a <= cmp_lhs;
            hold_b <= cmp_rhs;
        end
    end

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(cmp_valid) |-> ($stable(hold_a) && $stable(hold_b))); // R2

    AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(cmp_valid) |-> (hold_a == $past(cmp_lhs) && hold_b == $past(cmp_rhs))); // R2

endmodule

// File: rtl/cbr_word_decode.sv
module cbr_word_decode
    import cbr_pkg::*;
#(
    parameter int unsigned XLEN = CBR_XLEN
) (
    input  logic [CBR_IW-1:0] br_word,
    output br_fields_t        fields,
    output logic [XLEN-1:0]   offset
);

    localparam int unsigned EXT_W = XLEN - CBR_OFF_W - 1;

    logic [CBR_COND_W-1:0] code;

    always_comb begin
        code             = br_word[CBR_COND_LSB +: CBR_COND_W];
        fields.is_branch = br_word[CBR_IW-1] && br_word[CBR_IW-2];
        fields.cond_ok   = (code < CBR_COND_W'(CBR_NUM_RELS));
        fields.rel       = fields.cond_ok ? rel_e'(code) : REL_EQ;
        fields.off_raw   = br_word[CBR_OFF_W-1:0];
        offset = {{EXT_W{fields.off_raw[CBR_OFF_W-1]}}, fields.off_raw, 1'b0};
    end

endmodule

// File: rtl/cbr_rel_eval.sv
module cbr_rel_eval
    import cbr_pkg::*;
#(
    parameter int unsigned XLEN = CBR_XLEN
) (
    input  logic [XLEN-1:0] hold_a,
    input  logic [XLEN-1:0] hold_b,
    input  rel_e            rel,
    output logic            hit
);

    cmp_summary_t summ;

    always_comb begin
        summ.eq  = (hold_a == hold_b);
        summ.slt = ($signed(hold_a) < $signed(hold_b));
        summ.ult = (hold_a < hold_b);
        hit      = rel_pick(rel, summ);
    end

endmodule

// File: rtl/cbr_target_calc.sv
module cbr_target_calc
    import cbr_pkg::*;
#(
    parameter int unsigned XLEN = CBR_XLEN
) (
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] tgt_pc
);

    always_comb begin
        seq_pc = cur_pc + XLEN'(CBR_STEP);
        tgt_pc = seq_pc + offset;
    end

endmodule

// File: rtl/cbr_resolve_unit.sv
module cbr_resolve_unit
    import cbr_pkg::*;
#(
    parameter int unsigned XLEN = CBR_XLEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [CBR_IW-1:0] br_word,
    input  logic              br_valid,
    input  logic              cmp_valid,
    input  logic [XLEN-1:0]   cmp_lhs,
    input  logic [XLEN-1:0]   cmp_rhs,
    output logic [XLEN-1:0]   next_pc,
    output logic              br_taken,
    output logic              bad_cond
);

    logic [XLEN-1:0] hold_a, hold_b;
    logic [XLEN-1:0] offset, seq_pc, tgt_pc;
    br_fields_t      fields;
    logic            hit;

    cbr_hold_regs #(.XLEN(XLEN)) u_hold (
        .clk(clk), .rst(rst), .cmp_valid(cmp_valid),
        .cmp_lhs(cmp_lhs), .cmp_rhs(cmp_rhs),
        .hold_a(hold_a), .hold_b(hold_b)
    );

    cbr_word_decode #(.XLEN(XLEN)) u_dec (
        .br_word(br_word), .fields(fields), .offset(offset)
    );

    cbr_rel_eval #(.XLEN(XLEN)) u_eval (
        .hold_a(hold_a), .hold_b(hold_b), .rel(fields.rel), .hit(hit)
    );

    cbr_target_calc #(.XLEN(XLEN)) u_tgt (
        .cur_pc(cur_pc), .offset(offset), .seq_pc(seq_pc), .tgt_pc(tgt_pc)
    );

    logic            fire;
    logic [XLEN-1:0] pc_d;
    logic            taken_d, bad_d;

    always_comb begin
        fire = br_valid && fields.is_branch;
        if (!fields.cond_ok) begin
            pc_d    = cur_pc;
            taken_d = 1'b0;
            bad_d   = 1'b1;
        end else begin
            pc_d    = hit ? tgt_pc : seq_pc;
            taken_d = hit;
            bad_d   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc  <= '0;
            br_taken <= 1'b0;
            bad_cond <= 1'b0;
        end else if (fire) begin
            next_pc  <= pc_d;
            br_taken <= taken_d;
            bad_cond <= bad_d;
        end
    end

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_TAKEN_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(br_taken && bad_cond)); // R9

    AST_BAD_PC_KEPT: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(br_valid && br_word[CBR_IW-1] && br_word[CBR_IW-2]) && bad_cond)
        |-> (next_pc == $past(cur_pc))); // R9

    AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(br_valid && br_word[CBR_IW-1] && br_word[CBR_IW-2]) && !br_taken && !bad_cond)
        |-> (next_pc == $past(cur_pc) + XLEN'(CBR_STEP))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(br_valid) |-> ($stable(next_pc) && $stable(br_taken) && $stable(bad_cond))); // R10

    AST_NONBRANCH_HOLD: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(br_valid && !(br_word[CBR_IW-1] && br_word[CBR_IW-2]))
        |-> ($stable(next_pc) && $stable(br_taken) && $stable(bad_cond))); // R11

endmodule

// File: tb/cbr_resolve_unit_tb.sv
module cbr_resolve_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cur_pc = '0;
    logic [15:0] br_word = '0;
    logic        br_valid = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [31:0] cmp_lhs = '0;
    logic [31:0] cmp_rhs = '0;
    logic [31:0] next_pc;
    logic        br_taken;
    logic        bad_cond;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    cbr_resolve_unit u_dut (
        .clk(clk), .rst(rst), .cur_pc(cur_pc), .br_word(br_word),
        .br_valid(br_valid), .cmp_valid(cmp_valid), .cmp_lhs(cmp_lhs),
        .cmp_rhs(cmp_rhs), .next_pc(next_pc), .br_taken(br_taken),
        .bad_cond(bad_cond)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
        end
    endtask

    function automatic logic model_rel(input int code, input logic [31:0] a, input logic [31:0] b);
        case (code)
            0: return a == b;
            1: return a != b;
            2: return $signed(a) <  $signed(b);
            3: return $signed(a) >  $signed(b);
            4: return a <  b;
            5: return a >  b;
            6: return $signed(a) >= $signed(b);
            7: return $signed(a) <= $signed(b);
            8: return a >= b;
            9: return a <= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] model_off(input logic [9:0] off);
        return 32'($signed({off, 1'b0}));
    endfunction

    task automatic do_cmp(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_lhs = a; cmp_rhs = b;
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic do_br(input logic [31:0] pc, input logic [3:0] code, input logic [9:0] off);
        @(negedge clk);
        cur_pc = pc; br_word = {2'b11, code, off}; br_valid = 1'b1;
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 next_pc", next_pc, 32'h0);
        chk("R1 taken", {31'b0, br_taken}, 32'h0);
        chk("R1 bad", {31'b0, bad_cond}, 32'h0);
        do_br(32'h0000_0100, 4'd0, 10'h004);
        chk("R1 eq on reset pair", {31'b0, br_taken}, 32'h1);
        chk("R1 target", next_pc, 32'h0000_010A);
    endtask

    task automatic t_relations;
        logic [31:0] pa [5] = '{32'hFFFF_FFFF, 32'h1, 32'h5, 32'h8000_0000, 32'h3};
        logic [31:0] pb [5] = '{32'h1, 32'hFFFF_FFFF, 32'h5, 32'h7FFF_FFFF, 32'h9};
        for (int p = 0; p < 5; p++) begin
            do_cmp(pa[p], pb[p]);
            for (int c = 0; c < 10; c++) begin
                logic e;
                string tag;
                e = model_rel(c, pa[p], pb[p]);
                tag = (c < 2) ? "R4" : ((c == 2 || c == 3 || c == 6 || c == 7) ? "R5" : "R6");
                do_br(32'h0000_1000, 4'(c), 10'h010);
                chk({tag, " taken"}, {31'b0, br_taken}, {31'b0, e});
                chk(e ? "R7 target" : "R8 sequential", next_pc,
                    e ? 32'h0000_1022 : 32'h0000_1002);
                chk("R9 bad clear", {31'b0, bad_cond}, 32'h0);
            end
        end
    endtask

    task automatic t_offsets;
        logic [9:0] offs [4] = '{10'h1FF, 10'h200, 10'h3FF, 10'h000};
        do_cmp(32'h7, 32'h7);
        foreach (offs[i]) begin
            do_br(32'h0001_0000, 4'd0, offs[i]);
            chk("R7 offset", next_pc, 32'h0001_0002 + model_off(offs[i]));
        end
        do_br(32'h0001_0000, 4'd1, 10'h1FF);
        chk("R8 not taken", next_pc, 32'h0001_0002);
    endtask

    task automatic t_illegal;
        for (int c = 10; c < 16; c++) begin
            do_br(32'h0000_2000 + 32'(c * 4), 4'(c), 10'h0AA);
            chk("R9 bad", {31'b0, bad_cond}, 32'h1);
            chk("R9 not taken", {31'b0, br_taken}, 32'h0);
            chk("R9 pc kept", next_pc, 32'h0000_2000 + 32'(c * 4));
        end
        do_br(32'h0000_3000, 4'd0, 10'h000);
        chk("R9 cleared by legal", {31'b0, bad_cond}, 32'h0);
    endtask

    task automatic t_latch_gate;
        do_cmp(32'h5, 32'h5);
        @(negedge clk);
        cmp_lhs = 32'h7; cmp_rhs = 32'h9;
        @(negedge clk);
        do_br(32'h0000_4000, 4'd0, 10'h002);
        chk("R2 idle operands ignored", {31'b0, br_taken}, 32'h1);
    endtask

    task automatic t_same_cycle;
        do_cmp(32'h1, 32'h1);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_lhs = 32'h1; cmp_rhs = 32'h2;
        cur_pc = 32'h0000_5000; br_word = {2'b11, 4'd0, 10'h008}; br_valid = 1'b1;
        @(negedge clk);
        cmp_valid = 1'b0; br_valid = 1'b0;
        chk("R3 old pair used", {31'b0, br_taken}, 32'h1);
        chk("R3 old pair target", next_pc, 32'h0000_5012);
        do_br(32'h0000_5000, 4'd0, 10'h008);
        chk("R3 new pair next", {31'b0, br_taken}, 32'h0);
    endtask

    task automatic t_hold;
        do_cmp(32'h3, 32'h3);
        do_br(32'h0000_6000, 4'd0, 10'h010);
        repeat (3) @(negedge clk);
        chk("R10 hold pc", next_pc, 32'h0000_6022);
        do_cmp(32'h1, 32'h2);
        chk("R10 compare leaves outputs", next_pc, 32'h0000_6022);
        chk("R10 compare leaves taken", {31'b0, br_taken}, 32'h1);
    endtask

    task automatic t_nonbranch;
        @(negedge clk);
        cur_pc = 32'h0000_7000; br_word = 16'h8000; br_valid = 1'b1;
        @(negedge clk);
        br_word = 16'h7C00;
        @(negedge clk);
        br_valid = 1'b0;
        chk("R11 non-branch pc", next_pc, 32'h0000_6022);
        chk("R11 non-branch taken", {31'b0, br_taken}, 32'h1);
        chk("R11 non-branch bad", {31'b0, bad_cond}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_relations();
        t_offsets();
        t_illegal();
        t_latch_gate();
        t_same_cycle();
        t_hold();
        t_nonbranch();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired got=0x%08h exp=0x%08h", 32'h0, 32'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule